// File: doc/BRIEF.md
# Scoreboard Computational Unit Controller

This block is the control logic for one computational unit (a reservation station) in a scoreboard-style out-of-order core. It takes exactly one instruction through an issue handshake. It asks for a read of the source operands and waits for a go-read grant, then hands the operands to an attached function unit. It captures the result, asks for a write of the destination and waits for a go-write grant. Only after that grant is it free for the next instruction.

The phase state is three flags held in ordinary flip-flops: issued, read-pending and write-pending. They are linked so that control only ever moves forward and no undefined mix can arise. With a single-stage function unit, the operand handoff and the result capture are combinational. An instruction then occupies the unit for three cycles. With an N-stage function unit the occupancy rises to about 3 + N cycles. The core reaches full throughput by placing several such units side by side. A kill input drops the held instruction from any phase.

Top module: `cu_ctrl`

## Requirements
- R1: While and directly after reset, `busy_o`, `rd_req_o`, `wr_req_o` and `fu_valid_o` are all low.
- R2: An issue pulse on a cycle with `busy_o` low and `go_die_i` low is accepted. `busy_o` and `rd_req_o` are high from the next cycle on. An issue pulse while `busy_o` is high is ignored: the opcode later shown on `fu_op_o` stays the one first accepted.
- R3: `rd_req_o` stays high from acceptance until the cycle in which `go_rd_i` is high. A `go_rd_i` while `rd_req_o` is low has no effect. Before the grant, `fu_valid_o` is low.
- R4: In the cycle in which `go_rd_i` meets a high `rd_req_o`, `fu_valid_o` is high in that same cycle. In that cycle `fu_src_o` equals `src_i` (source k in bits [k*DW +: DW]) and `fu_op_o` equals the accepted opcode.
- R5: If `fu_ready_i` is low when operands are offered, `fu_valid_o` stays high in later cycles with the same operands and opcode, until `fu_ready_i` is high. Exactly one handoff is made per instruction. After it, `fu_valid_o` stays low.
- R6: `fu_res_valid_i` is taken in the handoff cycle or in any later cycle before the write is requested. From the next cycle, `wr_req_o` is high and `wr_data_o` equals the taken result. Both stay so until `go_wr_i`.
- R7: `go_wr_i` while `wr_req_o` is high frees the unit: `busy_o` and `wr_req_o` are low in the next cycle. `go_wr_i` at any other time has no effect.
- R8: `rd_req_o` and `wr_req_o` are never high together, and either one implies `busy_o`.
- R9: Suppose the grants come at once and the function unit is combinational and ready. Then acceptance to free takes 3 cycles. Every cycle of delay on go-read, ready stall, function-unit latency or go-write adds exactly one cycle.
- R10: `go_die_i` returns the unit to idle in the next cycle from any phase, with all requests and `fu_valid_o` low. It wins over an issue in the same cycle.
- R11: `fu_res_valid_i` has no effect while no handoff has been made, or while a write request is already pending. In particular, `wr_data_o` is not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_i | input | 1 | Issue request for a new instruction |
| opcode_i | input | OPW | Opcode presented with the issue |
| busy_o | output | 1 | Unit holds an instruction |
| rd_req_o | output | 1 | Request to read the source operands |
| go_rd_i | input | 1 | Read grant; `src_i` is valid with it |
| src_i | input | NSRC*DW | Source operands from the register file |
| fu_valid_o | output | 1 | Operands offered to the function unit |
| fu_ready_i | input | 1 | Function unit accepts the offer |
| fu_op_o | output | OPW | Opcode to the function unit |
| fu_src_o | output | NSRC*DW | Operands to the function unit |
| fu_res_valid_i | input | 1 | Function unit result valid |
| fu_res_i | input | DW | Function unit result |
| wr_req_o | output | 1 | Request to write the result |
| go_wr_i | input | 1 | Write grant |
| wr_data_o | output | DW | Result toward the register-file write port |
| go_die_i | input | 1 | Kill the held instruction |

## Verification
`busy_o` and `rd_req_o` are due one cycle after an accepted issue. `fu_valid_o`, `fu_src_o` and `fu_op_o` respond combinationally in the go-read cycle, so the bench checks them 1 ns after driving the grant, within the same cycle. `wr_req_o` and `wr_data_o` are due one cycle after the result is taken. Idle is due one cycle after a go-write or a kill. Inputs are driven 5 ns after the rising edge and registered outputs are compared at that point. The bench counts every step of each transaction and compares the total with 3 plus the injected delays.

// File: rtl/cu_pkg.sv
// Package: shared types for the computational unit controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cu_pkg;
    // The three cyclically linked phase flags.
    typedef struct packed {
        logic issued;   // an instruction is held
        logic rd_pend;  // waiting for go-read
        logic wr_pend;  // waiting for go-write
    } cu_flags_t;

    localparam cu_flags_t CU_IDLE = '{issued: 1'b0, rd_pend: 1'b0, wr_pend: 1'b0};
endpackage

// File: rtl/cu_phase_ctl.sv
// Module: phase control of one computational unit.
// Holds the issued / read-pending / write-pending flags plus a handoff-done
// flag, all in flip-flops. Produces the handshake strobes used by the
// operand and result holders.
// Assumes: synchronous active-low reset; kill has top priority.
module cu_phase_ctl
    import cu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic go_rd_i,
    input  logic go_wr_i,
    input  logic go_die_i,
    input  logic fu_ready_i,
    input  logic fu_res_valid_i,
    output logic busy_o,
    output logic rd_req_o,
    output logic wr_req_o,
    output logic fu_valid_o,
    output logic accept_o,
    output logic rd_grant_o,
    output logic res_take_o
);
    cu_flags_t flags_q, flags_d;
    logic      sent_q, sent_d;
    logic      fire;
    logic      wr_done;

    // Decode the handshake strobes from the current flags.
    always_comb begin
        accept_o   = issue_i & ~flags_q.issued & ~go_die_i;
        rd_grant_o = flags_q.rd_pend & go_rd_i;
        fu_valid_o = rd_grant_o
                   | (flags_q.issued & ~flags_q.rd_pend & ~flags_q.wr_pend & ~sent_q);
        fire       = fu_valid_o & fu_ready_i;
        res_take_o = fu_res_valid_i & flags_q.issued & ~flags_q.wr_pend & (sent_q | fire);
        wr_done    = flags_q.wr_pend & go_wr_i;
    end

    // Next-state logic: forward-only transitions, kill overrides all.
    always_comb begin
        flags_d = flags_q;
        sent_d  = sent_q;
        if (go_die_i) begin
            flags_d = CU_IDLE;
            sent_d  = 1'b0;
        end else begin
            if (accept_o) begin
                flags_d.issued  = 1'b1;
                flags_d.rd_pend = 1'b1;
                sent_d          = 1'b0;
            end
            if (rd_grant_o) flags_d.rd_pend = 1'b0;
            if (fire)       sent_d          = 1'b1;
            if (res_take_o) flags_d.wr_pend = 1'b1;
            if (wr_done) begin
                flags_d = CU_IDLE;
                sent_d  = 1'b0;
            end
        end
    end

    // Phase register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= CU_IDLE;
            sent_q  <= 1'b0;
        end else begin
            flags_q <= flags_d;
            sent_q  <= sent_d;
        end
    end

    // Outputs that follow the flags directly.
    assign busy_o   = flags_q.issued;
    assign rd_req_o = flags_q.rd_pend;
    assign wr_req_o = flags_q.wr_pend;
endmodule

// File: rtl/cu_operand_hold.sv
// Module: opcode and operand holding registers.
// Latches the opcode on issue acceptance and each source operand on the
// read grant; in the grant cycle the live register-file values pass
// straight through so a single-stage function unit sees them at once.
// Assumes: strobes come from cu_phase_ctl.
module cu_operand_hold #(
    parameter int OPW  = 4,
    parameter int DW   = 16,
    parameter int NSRC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                rd_grant_i,
    input  logic [OPW-1:0]      opcode_i,
    input  logic [NSRC*DW-1:0]  src_i,
    output logic [OPW-1:0]      fu_op_o,
    output logic [NSRC*DW-1:0]  fu_src_o
);
    logic [OPW-1:0] op_q;

    // Opcode register, loaded once per instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)        op_q <= '0;
        else if (accept_i) op_q <= opcode_i;
    end
    assign fu_op_o = op_q;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        logic [DW-1:0] src_q;

        // Operand k register, loaded on the read grant.
        always_ff @(posedge clk) begin
            if (!rst_n)          src_q <= '0;
            else if (rd_grant_i) src_q <= src_i[k*DW +: DW];
        end

        // Operand k to the function unit: live in grant cycle, held after.
        assign fu_src_o[k*DW +: DW] = rd_grant_i ? src_i[k*DW +: DW] : src_q;
    end
endmodule

// File: rtl/cu_result_hold.sv
// Module: result register feeding the register-file write port.
// Assumes: take strobe is high only once per instruction.
module cu_result_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [DW-1:0] res_i,
    output logic [DW-1:0] wr_data_o
);
    logic [DW-1:0] res_q;

    // Capture the function-unit result when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (take_i) res_q <= res_i;
    end
    assign wr_data_o = res_q;
endmodule

// File: rtl/cu_ctrl.sv
// Module: top of the computational unit controller.
// Connects the phase control, the operand holder and the result holder.
// Assumes: dependency matrices drive go_rd_i / go_wr_i only against the
// matching request; the function unit honours fu_valid_o / fu_ready_i.
module cu_ctrl #(
    parameter int OPW  = 4,
    parameter int DW   = 16,
    parameter int NSRC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic [OPW-1:0]      opcode_i,
    output logic                busy_o,
    output logic                rd_req_o,
    input  logic                go_rd_i,
    input  logic [NSRC*DW-1:0]  src_i,
    output logic                fu_valid_o,
    input  logic                fu_ready_i,
    output logic [OPW-1:0]      fu_op_o,
    output logic [NSRC*DW-1:0]  fu_src_o,
    input  logic                fu_res_valid_i,
    input  logic [DW-1:0]       fu_res_i,
    output logic                wr_req_o,
    input  logic                go_wr_i,
    output logic [DW-1:0]       wr_data_o,
    input  logic                go_die_i
);
    logic accept;
    logic rd_grant;
    logic res_take;

    // Phase flags and handshake strobes.
    cu_phase_ctl i_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_i        (issue_i),
        .go_rd_i        (go_rd_i),
        .go_wr_i        (go_wr_i),
        .go_die_i       (go_die_i),
        .fu_ready_i     (fu_ready_i),
        .fu_res_valid_i (fu_res_valid_i),
        .busy_o         (busy_o),
        .rd_req_o       (rd_req_o),
        .wr_req_o       (wr_req_o),
        .fu_valid_o     (fu_valid_o),
        .accept_o       (accept),
        .rd_grant_o     (rd_grant),
        .res_take_o     (res_take)
    );

    // Opcode and operands toward the function unit.
    cu_operand_hold #(.OPW(OPW), .DW(DW), .NSRC(NSRC)) i_opnd (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .rd_grant_i (rd_grant),
        .opcode_i   (opcode_i),
        .src_i      (src_i),
        .fu_op_o    (fu_op_o),
        .fu_src_o   (fu_src_o)
    );

    // Result toward the register-file write port.
    cu_result_hold #(.DW(DW)) i_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (res_take),
        .res_i     (fu_res_i),
        .wr_data_o (wr_data_o)
    );
endmodule

// File: rtl/cu_ctrl_chk.sv
// Module: property checker for cu_ctrl, bound to every instance.
// Assumes: observes ports only.
module cu_ctrl_chk #(
    parameter int OPW  = 4,
    parameter int DW   = 16,
    parameter int NSRC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_i,
    input logic               busy_o,
    input logic               rd_req_o,
    input logic               go_rd_i,
    input logic               fu_valid_o,
    input logic               fu_ready_i,
    input logic [OPW-1:0]     fu_op_o,
    input logic [NSRC*DW-1:0] fu_src_o,
    input logic               wr_req_o,
    input logic               go_wr_i,
    input logic [DW-1:0]      wr_data_o,
    input logic               go_die_i
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !rd_req_o && !wr_req_o && !fu_valid_o));

    assert_issue_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !busy_o && !go_die_i) |=> (busy_o && rd_req_o));

    assert_rd_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !go_rd_i && !go_die_i) |=> rd_req_o);

    assert_grant_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && go_rd_i) |-> fu_valid_o);

    assert_offer_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_valid_o && !fu_ready_i && !go_die_i)
        |=> (fu_valid_o && $stable(fu_src_o) && $stable(fu_op_o)));

    assert_wr_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !go_wr_i && !go_die_i) |=> (wr_req_o && $stable(wr_data_o)));

    assert_write_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && go_wr_i && !go_die_i) |=> (!busy_o && !wr_req_o));

    assert_req_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    assert_req_implies_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o || wr_req_o) |-> busy_o);

    assert_kill_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go_die_i |=> (!busy_o && !rd_req_o && !wr_req_o && !fu_valid_o));
endmodule

bind cu_ctrl cu_ctrl_chk #(.OPW(OPW), .DW(DW), .NSRC(NSRC)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .go_rd_i    (go_rd_i),
    .fu_valid_o (fu_valid_o),
    .fu_ready_i (fu_ready_i),
    .fu_op_o    (fu_op_o),
    .fu_src_o   (fu_src_o),
    .wr_req_o   (wr_req_o),
    .go_wr_i    (go_wr_i),
    .wr_data_o  (wr_data_o),
    .go_die_i   (go_die_i)
);

// File: tb/test_cu_ctrl.sv
module test_cu_ctrl;
    localparam int OPW  = 4;
    localparam int DW   = 16;
    localparam int NSRC = 2;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                issue;
    logic [OPW-1:0]      opcode;
    logic                busy, rd_req, go_rd, fu_valid, fu_ready;
    logic [NSRC*DW-1:0]  src, fu_src;
    logic [OPW-1:0]      fu_op;
    logic                fu_res_valid;
    logic [DW-1:0]       fu_res, wr_data;
    logic                wr_req, go_wr, go_die;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    cu_ctrl #(.OPW(OPW), .DW(DW), .NSRC(NSRC)) i_cu_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .opcode_i(opcode),
        .busy_o(busy), .rd_req_o(rd_req), .go_rd_i(go_rd), .src_i(src),
        .fu_valid_o(fu_valid), .fu_ready_i(fu_ready), .fu_op_o(fu_op),
        .fu_src_o(fu_src), .fu_res_valid_i(fu_res_valid), .fu_res_i(fu_res),
        .wr_req_o(wr_req), .go_wr_i(go_wr), .wr_data_o(wr_data), .go_die_i(go_die)
    );

    function automatic logic [DW-1:0] fu_model(logic [OPW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op[1:0])
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a ^ b;
            default: return a & b;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic idle_inputs();
        issue = 0; opcode = '0; go_rd = 0; src = '0; fu_ready = 0;
        fu_res_valid = 0; fu_res = '0; go_wr = 0; go_die = 0;
    endtask

    // One instruction with injected delays; checks every phase.
    task automatic run_instr(logic [OPW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b,
                             int rdd, int stall, int lat, int wrd);
        logic [DW-1:0] exp;
        int n;
        exp = fu_model(op, a, b);
        n = 0;
        chk("R2 idle before issue", busy, 0);
        issue = 1; opcode = op;
        step(); n++;
        issue = 0;
        chk("R2 busy after issue", busy, 1);
        chk("R2 rd_req after issue", rd_req, 1);
        for (int i = 0; i < rdd; i++) begin
            issue = 1; opcode = ~op;
            fu_res_valid = 1; fu_res = 16'hdead; go_wr = 1;
            #1;
            chk("R3 no offer before grant", fu_valid, 0);
            step(); n++;
            issue = 0; fu_res_valid = 0; go_wr = 0;
            chk("R3 rd_req held", rd_req, 1);
            chk("R11 no wr_req before handoff", wr_req, 0);
            chk("R7 go_wr ignored while reading", busy, 1);
        end
        go_rd = 1; src = {b, a}; fu_ready = (stall == 0);
        if (stall == 0 && lat == 0) begin fu_res_valid = 1; fu_res = exp; end
        #1;
        chk("R4 offer in grant cycle", fu_valid, 1);
        chk("R4 live operands", fu_src, {b, a});
        chk("R2 R4 opcode kept", fu_op, op);
        step(); n++;
        go_rd = 0; src = $urandom; fu_res_valid = 0;
        for (int s = 0; s < stall; s++) begin
            fu_ready = (s == stall - 1);
            if (fu_ready && lat == 0) begin fu_res_valid = 1; fu_res = exp; end
            #1;
            chk("R5 offer held", fu_valid, 1);
            chk("R5 operands held", fu_src, {b, a});
            chk("R5 opcode held", fu_op, op);
            step(); n++;
            fu_res_valid = 0;
        end
        if (lat > 0) begin
            for (int l = 0; l < lat - 1; l++) begin
                fu_ready = 1;
                #1;
                chk("R5 single handoff", fu_valid, 0);
                chk("R6 no wr_req before result", wr_req, 0);
                step(); n++;
            end
            fu_res_valid = 1; fu_res = exp;
            #1;
            chk("R5 single handoff at result", fu_valid, 0);
            step(); n++;
            fu_res_valid = 0;
        end
        chk("R6 wr_req after result", wr_req, 1);
        chk("R6 wr_data", wr_data, exp);
        chk("R8 rd_req low while writing", rd_req, 0);
        for (int w = 0; w < wrd; w++) begin
            fu_res_valid = 1; fu_res = ~exp; go_rd = 1;
            step(); n++;
            fu_res_valid = 0; go_rd = 0;
            chk("R11 wr_data not overwritten", wr_data, exp);
            chk("R6 wr_req held", wr_req, 1);
        end
        go_wr = 1;
        step(); n++;
        go_wr = 0;
        chk("R7 free after go_wr", busy, 0);
        chk("R7 wr_req low after go_wr", wr_req, 0);
        chk("R9 occupancy cycles", n, 3 + rdd + stall + lat + wrd);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R9 actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst_n = 0;
        step(); step();
        chk("R1 busy in reset", busy, 0);
        chk("R1 rd_req in reset", rd_req, 0);
        chk("R1 wr_req in reset", wr_req, 0);
        chk("R1 fu_valid in reset", fu_valid, 0);
        rst_n = 1;
        step();
        chk("R1 busy after reset", busy, 0);
        chk("R1 wr_req after reset", wr_req, 0);

        // Directed: stray grants and results while idle.
        go_rd = 1; go_wr = 1; fu_res_valid = 1;
        step();
        go_rd = 0; go_wr = 0; fu_res_valid = 0;
        chk("R3 idle go_rd ignored", rd_req, 0);
        chk("R7 idle go_wr ignored", busy, 0);
        chk("R11 idle result ignored", wr_req, 0);

        // Directed: minimum path, then a pipelined one.
        run_instr(4'h0, 16'h1234, 16'h0101, 0, 0, 0, 0);
        run_instr(4'h1, 16'h8000, 16'h0001, 1, 2, 3, 1);

        // Kill racing an issue while idle.
        issue = 1; go_die = 1; opcode = 4'h3;
        step();
        issue = 0; go_die = 0;
        chk("R10 kill beats issue", busy, 0);
        chk("R10 no rd_req after kill", rd_req, 0);

        // Kill while waiting for go-read.
        issue = 1; opcode = 4'h2; step(); issue = 0;
        go_die = 1; step(); go_die = 0;
        chk("R10 kill in read wait", busy, 0);
        chk("R10 rd_req cleared", rd_req, 0);

        // Kill while operands are stalled at the function unit.
        issue = 1; step(); issue = 0;
        go_rd = 1; src = 32'h00050007; fu_ready = 0; step(); go_rd = 0;
        chk("R5 stalled offer before kill", fu_valid, 1);
        go_die = 1; step(); go_die = 0;
        chk("R10 kill clears offer", fu_valid, 0);
        chk("R10 kill in exec", busy, 0);

        // Kill while waiting for go-write.
        issue = 1; step(); issue = 0;
        go_rd = 1; fu_ready = 1; fu_res_valid = 1; fu_res = 16'h4242; step();
        go_rd = 0; fu_res_valid = 0;
        chk("R6 wr_req before kill", wr_req, 1);
        go_die = 1; step(); go_die = 0;
        chk("R10 kill clears wr_req", wr_req, 0);
        chk("R10 kill in write wait", busy, 0);

        // Constrained random instructions.
        for (int t = 0; t < 300; t++) begin
            run_instr(OPW'($urandom), DW'($urandom), DW'($urandom),
                      $urandom % 3, $urandom % 3, $urandom % 4, $urandom % 3);
            if ($urandom % 4 == 0) step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule